// File: doc/BRIEF.md
# Shared-Bus Packet Read Scheduler

This block lets four source FIFOs share a single data bus. Each FIFO feeds one output path of its own, so the index chosen for a transfer names both the source FIFO and the output path that the word goes to. The block watches the non-empty flag of every FIFO. When at least one has data, it picks one FIFO in round-robin order and pulses that FIFO's read enable once per cycle until the burst ends.

A burst ends when the word on the bus carries end-of-packet, or when the number of words reaches a programmable limit, whichever comes first.

The choice of FIFO is not made by the controller's transition logic. A separate selection pipeline computes it, with registers between its levels. The controller steps through four one-hot states: idle, schedule, a wait step that covers the selection pipeline's latency, and read. The chosen index is held on the output from the start of a burst until the next burst starts.

Top module: `bus_read_sched`

## Requirements
- R1: After reset, `rd_en` is 0, `bus_valid` is 0, and `sel_idx` is 3. The value 3 marks FIFO 3 as the one served last, so FIFO 0 has first priority.
- R2: While every bit of `src_nonempty` is 0 in the idle state, no burst starts, and `rd_en` and `bus_valid` stay 0.
- R3: Suppose the block is idle and some `src_nonempty` bit is 1 at clock edge E. Then `bus_valid` first rises after edge E+2, which is three edges counting E. The controller spends one cycle in schedule and one cycle in wait before reading.
- R4: The FIFO chosen is the first requesting one, counting upward with wrap from the FIFO served last. The request pattern used is the one sampled at the edge that leaves idle.
- R5: `sel_idx` changes only at the edge that starts a burst, and it holds through the whole burst and the gap that follows.
- R6: `burst_max` is sampled at the edge that leaves the schedule state. A burst that sees no end-of-packet ends after exactly that many words. A limit of 0 acts as 1.
- R7: A read cycle in which `rd_eop` is 1 is the last word of its burst, and that word is still read.
- R8: In a read cycle, `rd_en` is one-hot with the bit at position `sel_idx` set. Outside read cycles it is 0. `bus_valid` equals the OR of `rd_en`.
- R9: Between two bursts, `bus_valid` stays low for at least three cycles: one idle, one schedule and one wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_nonempty | input | 4 | Per-FIFO flag, 1 = data waiting; bit i belongs to FIFO i |
| rd_eop | input | 1 | End-of-packet flag of the word read this cycle |
| burst_max | input | 10 | Maximum words per burst (0 treated as 1) |
| rd_en | output | 4 | Per-FIFO read enable, bit i reads FIFO i |
| sel_idx | output | 2 | Index of the FIFO being served and of its output path |
| bus_valid | output | 1 | Shared bus carries a word this cycle |

## Verification
A burst becomes visible three edges after the idle controller first sees a request. The bench checks this exactly: after raising a request, it samples `bus_valid` low at the first two falling edges and high at the third.

Read enables, bus valid and the selected index all change at the edge of the cycle they belong to. The bench therefore steps a behavioural model at every rising edge and compares all three outputs at the next falling edge. The burst length and the end-of-packet stop are due in the same cycle as the word that ends the burst, so the model counts words and closes each burst at that same edge.

// File: rtl/bus_sched_pkg.sv
package bus_sched_pkg;
  typedef enum logic [3:0] {
    ST_IDLE  = 4'b0001,
    ST_SCHED = 4'b0010,
    ST_WAIT  = 4'b0100,
    ST_READ  = 4'b1000
  } sched_st_e;
endpackage

// File: rtl/rr_pick_pipe.sv
module rr_pick_pipe #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_in,
  input  logic [IW-1:0] last_idx,
  output logic [IW-1:0] win_idx
);
  logic [N-1:0]  req_q;
  logic [IW-1:0] pick_d;
  logic          found;

  // level 1: register request flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_in;
  end

  // level 2: rotate from the last served index
  always_comb begin
    pick_d = last_idx;
    found  = 1'b0;
    for (int k = 1; k <= N; k++) begin
      if (!found && req_q[IW'((int'(last_idx) + k) % N)]) begin
        pick_d = IW'((int'(last_idx) + k) % N);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_idx <= IW'(N - 1);
    else        win_idx <= pick_d;
  end
endmodule

// File: rtl/burst_ctr.sv
module burst_ctr #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_lim,
  input  logic [CW-1:0] lim_in,
  input  logic          clr,
  input  logic          inc,
  output logic          last_word
);
  localparam int XW = CW + 1;
  logic [CW-1:0] lim_q, cnt_q;
  logic [XW-1:0] lim_eff, cnt_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lim_q <= '0;
    else if (load_lim) lim_q <= lim_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign lim_eff   = (lim_q == '0) ? XW'(1) : {1'b0, lim_q};
  assign cnt_nxt   = {1'b0, cnt_q} + XW'(1);
  assign last_word = (cnt_nxt >= lim_eff);
endmodule

// File: rtl/sched_fsm.sv
module sched_fsm
  import bus_sched_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      any_req,
  input  logic      eop,
  input  logic      last_word,
  output sched_st_e st
);
  sched_st_e st_d;

  always_comb begin
    st_d = st;
    case (st)
      ST_IDLE:  if (any_req) st_d = ST_SCHED;
      ST_SCHED: st_d = ST_WAIT;
      ST_WAIT:  st_d = ST_READ;
      ST_READ:  if (eop || last_word) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_d;
  end
endmodule

// File: rtl/bus_read_sched.sv
module bus_read_sched
  import bus_sched_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int CNT_W   = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         src_nonempty,
  input  logic                       rd_eop,
  input  logic [CNT_W-1:0]           burst_max,
  output logic [NUM_SRC-1:0]         rd_en,
  output logic [$clog2(NUM_SRC)-1:0] sel_idx,
  output logic                       bus_valid
);
  localparam int IW = $clog2(NUM_SRC);

  sched_st_e     st;
  logic [IW-1:0] win_idx;
  logic          last_word;
  logic          in_read;
  logic          sel_en;

  rr_pick_pipe #(.N(NUM_SRC), .IW(IW)) u_pick (
    .clk(clk), .rst_n(rst_n), .req_in(src_nonempty),
    .last_idx(sel_idx), .win_idx(win_idx)
  );

  burst_ctr #(.CW(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .load_lim(st == ST_SCHED), .lim_in(burst_max),
    .clr(st == ST_WAIT), .inc(in_read), .last_word(last_word)
  );

  sched_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .any_req(|src_nonempty),
    .eop(rd_eop), .last_word(last_word), .st(st)
  );

  assign in_read = (st == ST_READ);
  assign sel_en  = (st == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_idx <= IW'(NUM_SRC - 1);
    else if (sel_en) sel_idx <= win_idx;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_rden
    assign rd_en[i] = in_read && (sel_idx == IW'(i));
  end

  assign bus_valid = in_read;
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  src_nonempty,
  input logic [N-1:0]  rd_en,
  input logic [IW-1:0] sel_idx,
  input logic          bus_valid
);
  AST_RDEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_en)); // R8
  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid == (|rd_en)); // R8
  AST_RDEN_AT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> rd_en[sel_idx]); // R8
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_valid) && bus_valid) |-> $stable(sel_idx)); // R5
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_valid) |=> !bus_valid ##1 !bus_valid); // R9
  AST_START_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> $past(|src_nonempty, 3)); // R3
endmodule

bind bus_read_sched sched_chk #(.N(NUM_SRC), .IW($clog2(NUM_SRC))) u_chk (
  .clk(clk), .rst_n(rst_n), .src_nonempty(src_nonempty),
  .rd_en(rd_en), .sel_idx(sel_idx), .bus_valid(bus_valid)
);

// File: tb/sim_bus_read_sched.sv
`timescale 1ns/1ps
module sim_bus_read_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_nonempty = '0;
  logic       rd_eop = 1'b0;
  logic [9:0] burst_max = 10'd4;
  logic [3:0] rd_en;
  logic [1:0] sel_idx;
  logic       bus_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  bus_read_sched u0 (
    .clk(clk), .rst_n(rst_n), .src_nonempty(src_nonempty), .rd_eop(rd_eop),
    .burst_max(burst_max), .rd_en(rd_en), .sel_idx(sel_idx), .bus_valid(bus_valid)
  );

  // behavioural reference: 0 idle, 1 schedule, 2 wait, 3 read
  int m_st, m_sel, m_pick, m_lim, m_cnt;
  int m_snap;

  function automatic int rr_next(int reqs, int last);
    for (int k = 1; k <= 4; k++)
      if (reqs[(last + k) % 4]) return (last + k) % 4;
    return last;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_sel = 3; m_pick = 3; m_lim = 0; m_cnt = 0; m_snap = 0;
    end else begin
      case (m_st)
        0: if (src_nonempty != 0) begin m_snap = src_nonempty; m_st = 1; end
        1: begin m_lim = burst_max; m_pick = rr_next(m_snap, m_sel); m_st = 2; end
        2: begin m_sel = m_pick; m_cnt = 0; m_st = 3; end
        default: begin
          m_cnt++;
          if (rd_eop || m_cnt >= ((m_lim == 0) ? 1 : m_lim)) m_st = 0;
        end
      endcase
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cmp("rd_en R8", rd_en, (m_st == 3) ? (1 << m_sel) : 0);
    cmp("bus_valid R8", bus_valid, (m_st == 3) ? 1 : 0);
    cmp("sel_idx R4/R5", sel_idx, m_sel);
  endtask

  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) begin
      step();
      if (mode == 1) rd_eop = ((i % 7) == 3);
      if (mode == 2) begin
        src_nonempty = 4'((i * 5 + 3) % 16);
        burst_max    = 10'((i * 3) % 6);
        rd_eop       = ((i % 5) == 2);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    cmp("reset rd_en R1", rd_en, 0);
    cmp("reset bus_valid R1", bus_valid, 0);
    cmp("reset sel_idx R1", sel_idx, 3);
    rst_n = 1'b1;

    tag = "R2";
    run(10, 0);
    cmp("idle no request R2", bus_valid, 0);

    tag = "R3";
    src_nonempty = 4'b0100; burst_max = 10'd3;
    step(); cmp("latency edge1 R3", bus_valid, 0);
    step(); cmp("latency edge2 R3", bus_valid, 0);
    step(); cmp("latency edge3 R3", bus_valid, 1);
    cmp("chosen fifo R4", sel_idx, 2);
    src_nonempty = 4'b0000;
    run(2, 0);
    step(); cmp("three-word limit R6", bus_valid, 0);
    run(4, 0);

    tag = "R4";
    src_nonempty = 4'b1111; burst_max = 10'd2;
    run(40, 0);

    tag = "R6";
    burst_max = 10'd0;
    run(20, 0);
    burst_max = 10'd6;
    run(4, 0);
    burst_max = 10'd1;
    run(30, 0);

    tag = "R7";
    burst_max = 10'd1023;
    run(60, 1);
    rd_eop = 1'b0;

    tag = "R9";
    run(200, 2);
    src_nonempty = '0; rd_eop = 1'b0;
    run(30, 0);
    cmp("quiet at end R9", bus_valid, 0);
    done = 1;
  end

  initial begin
    int wd = 0;
    while (!done && wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", wd);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule